// File: doc/BRIEF.md
# Code-Bus Address Alias Remapper

This block sits on the instruction/code bus of a Harvard-style core. The system bus of that core registers every instruction or vector fetch whose address is at or above 0x2000_0000, which costs one extra cycle. To avoid that cost, fixed windows of the code-bus address space below 0x2000_0000 are aliases of physical regions that lie higher in the map. Each code-bus request is decoded against these windows. A hit is rewritten to its physical address and issued on the fast code channel one cycle after the request. A request already at a system address is passed on unchanged on the system channel after one more register stage.

The channel an access leaves on is the bus select. Its timing is the latency tag: code channel plus zero, system channel plus one. The code channel also carries a region code that names the window hit. A request below 0x2000_0000 that lands in no enabled window raises an error flag, and no access is issued for it. Each window can be removed at build time through a parameter mask.

Top module: `cb_alias_remap`

## Requirements
- R1: After reset, and before any request, `code_vld_o`, `sys_vld_o` and `err_o` are low.
- R2: A request in 0x0000_0000..0x007F_FFFF appears on the code channel one cycle later with the address unchanged and region code 0.
- R3: A request in 0x0080_0000..0x0FFF_FFFF is issued on the code channel at 0x8080_0000 plus its offset into the window, with region code 1.
- R4: A request in 0x1000_0000..0x17FF_FFFF is issued on the code channel at 0x2000_0000 plus its offset, with region code 2.
- R5: A request in 0x1800_0000..0x1EFF_FFFF is issued on the code channel at 0x3000_0000 plus its offset, with region code 3.
- R6: A request in 0x1F00_0000..0x1F7F_FFFF is issued on the code channel at 0x3F00_0000 plus its offset, with region code 4.
- R7: A request in 0x1F80_0000..0x1FFF_FFFF reaches the code channel with the address unchanged and region code 5.
- R8: An aliased request reaches the code channel one cycle after the request, the same cycle as an unaliased request, even though its physical address is at or above 0x2000_0000.
- R9: A request at or above 0x2000_0000 appears on the system channel with the address unchanged two cycles after the request. It never appears on the code channel.
- R10: When bit i of `WIN_EN` is clear, where i is the region code of the window, a request in that window raises `err_o` for one cycle, one cycle after the request. No access is issued on either channel for it.
- R11: A cycle without `req_valid_i` produces no code-channel access and no error in the following cycle.
- R12: A system-address request followed in the next cycle by a code-window request yields both accesses, in the same cycle, on their two channels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Fetch request valid |
| req_addr_i | input | 32 | Code-bus fetch address |
| code_vld_o | output | 1 | Access issued on the fast code channel |
| code_addr_o | output | 32 | Translated physical address on the code channel |
| code_rgn_o | output | 3 | Region code of the window hit (0..5) |
| sys_vld_o | output | 1 | Access issued on the delayed system channel |
| sys_addr_o | output | 32 | Address on the system channel |
| err_o | output | 1 | Request hit no enabled window; nothing issued |

## Verification
The bench builds two copies of the block. The first uses the default `WIN_EN` of all ones, and there every address below 0x2000_0000 belongs to some window, so all six windows and their edges are covered. The second uses `WIN_EN = 6'b110011`, which removes the serial-flash and parallel-bus aliases. That copy is the only way to reach the error path: the same window-edge addresses must raise `err_o` with both channels silent, while the other windows still translate as before. Both copies also see back-to-back system and code requests, to show that the one-stage skew between the channels loses nothing.

// File: rtl/cb_remap_pkg.sv
package cb_remap_pkg;

  localparam int unsigned AW    = 32;
  localparam int unsigned N_WIN = 6;

  localparam logic [AW-1:0] SYS_BASE = 32'h2000_0000;

  typedef enum logic [2:0] {
    RGN_ROM  = 3'd0,
    RGN_DRAM = 3'd1,
    RGN_QSPI = 3'd2,
    RGN_PBUS = 3'd3,
    RGN_SRAM = 3'd4,
    RGN_TCM  = 3'd5,
    RGN_NONE = 3'd6
  } rgn_e;

  function automatic logic [AW-1:0] win_lo(int unsigned i);
    case (i)
      0:       return 32'h0000_0000;
      1:       return 32'h0080_0000;
      2:       return 32'h1000_0000;
      3:       return 32'h1800_0000;
      4:       return 32'h1F00_0000;
      default: return 32'h1F80_0000;
    endcase
  endfunction

  function automatic logic [AW-1:0] win_hi(int unsigned i);
    case (i)
      0:       return 32'h007F_FFFF;
      1:       return 32'h0FFF_FFFF;
      2:       return 32'h17FF_FFFF;
      3:       return 32'h1EFF_FFFF;
      4:       return 32'h1F7F_FFFF;
      default: return 32'h1FFF_FFFF;
    endcase
  endfunction

  // physical address of the window's first byte
  function automatic logic [AW-1:0] win_dst(int unsigned i);
    case (i)
      0:       return 32'h0000_0000;
      1:       return 32'h8080_0000;
      2:       return 32'h2000_0000;
      3:       return 32'h3000_0000;
      4:       return 32'h3F00_0000;
      default: return 32'h1F80_0000;
    endcase
  endfunction

endpackage

// File: rtl/cb_alias_window.sv
module cb_alias_window
  import cb_remap_pkg::*;
#(
  parameter int unsigned IDX = 0,
  parameter bit          EN  = 1'b1
) (
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic [AW-1:0] xlat_o
);

  localparam logic [AW-1:0] LO   = win_lo(IDX);
  localparam logic [AW-1:0] SPAN = win_hi(IDX) - win_lo(IDX);
  localparam logic [AW-1:0] DST  = win_dst(IDX);

  logic [AW-1:0] off;

  // single unsigned compare on the offset covers both window bounds
  assign off    = addr_i - LO;
  assign hit_o  = EN && (off <= SPAN);
  assign xlat_o = DST + off;

endmodule

// File: rtl/cb_alias_decode.sv
module cb_alias_decode
  import cb_remap_pkg::*;
#(
  parameter logic [N_WIN-1:0] WIN_EN = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  output logic          hit_o,
  output logic          sys_o,
  output logic [AW-1:0] xlat_o,
  output rgn_e          rgn_o
);

  logic [N_WIN-1:0] hit_vec;
  logic [AW-1:0]    xlat_arr [N_WIN];

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    cb_alias_window #(
      .IDX (w),
      .EN  (WIN_EN[w])
    ) u_win (
      .addr_i (addr_i),
      .hit_o  (hit_vec[w]),
      .xlat_o (xlat_arr[w])
    );
  end

  assign sys_o = (addr_i >= SYS_BASE);

  always_comb begin
    hit_o  = 1'b0;
    xlat_o = addr_i;
    rgn_o  = RGN_NONE;
    for (int w = 0; w < N_WIN; w++) begin
      if (hit_vec[w]) begin
        hit_o  = 1'b1;
        xlat_o = xlat_arr[w];
        rgn_o  = rgn_e'(3'(w));
      end
    end
  end

  // windows are disjoint and all lie below the system base
  p_win_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec));
  p_win_not_sys_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_o |-> (hit_vec == '0));

endmodule

// File: rtl/cb_sys_delay.sv
module cb_sys_delay
  import cb_remap_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic [AW-1:0] addr_i,
  output logic          vld_o,
  output logic [AW-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      addr_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) addr_o <= addr_i;
    end
  end

  p_sys_stage_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> (vld_o && addr_o == $past(addr_i)));

endmodule

// File: rtl/cb_alias_remap.sv
module cb_alias_remap
  import cb_remap_pkg::*;
#(
  parameter logic [N_WIN-1:0] WIN_EN = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  logic [31:0]   req_addr_i,
  output logic          code_vld_o,
  output logic [31:0]   code_addr_o,
  output logic [2:0]    code_rgn_o,
  output logic          sys_vld_o,
  output logic [31:0]   sys_addr_o,
  output logic          err_o
);

  logic          dec_hit, dec_sys;
  logic [AW-1:0] dec_xlat;
  rgn_e          dec_rgn;

  logic          code_vld_q, err_q, sys_vld_q;
  logic [AW-1:0] code_addr_q, sys_addr_q;
  rgn_e          rgn_q;

  cb_alias_decode #(
    .WIN_EN (WIN_EN)
  ) u_dec (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .addr_i (req_addr_i),
    .hit_o  (dec_hit),
    .sys_o  (dec_sys),
    .xlat_o (dec_xlat),
    .rgn_o  (dec_rgn)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_vld_q  <= 1'b0;
      code_addr_q <= '0;
      rgn_q       <= RGN_NONE;
      err_q       <= 1'b0;
      sys_vld_q   <= 1'b0;
      sys_addr_q  <= '0;
    end else begin
      code_vld_q <= req_valid_i && dec_hit;
      err_q      <= req_valid_i && !dec_hit && !dec_sys;
      sys_vld_q  <= req_valid_i && dec_sys;
      if (req_valid_i && dec_hit) begin
        code_addr_q <= dec_xlat;
        rgn_q       <= dec_rgn;
      end
      if (req_valid_i && dec_sys) sys_addr_q <= req_addr_i;
    end
  end

  // system-address fetches take the registered slow path
  cb_sys_delay u_sys (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (sys_vld_q),
    .addr_i (sys_addr_q),
    .vld_o  (sys_vld_o),
    .addr_o (sys_addr_o)
  );

  assign code_vld_o  = code_vld_q;
  assign code_addr_o = code_addr_q;
  assign code_rgn_o  = rgn_q;
  assign err_o       = err_q;

  p_sys_two_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i >= SYS_BASE) |=> ##1
      (sys_vld_o && sys_addr_o == $past(req_addr_i, 2)));
  p_code_one_cycle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_addr_i < SYS_BASE) |=> (code_vld_o ^ err_o));
  p_alias_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_vld_o && code_rgn_o inside {3'd1, 3'd2, 3'd3, 3'd4})
      |-> (code_addr_o >= SYS_BASE));
  p_rom_low_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_vld_o && code_rgn_o == 3'd0) |-> (code_addr_o <= 32'h007F_FFFF));
  p_err_no_issue_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !code_vld_o);
  p_err_no_sys_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !sys_vld_o);
  p_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!code_vld_o && !err_o));

endmodule

// File: tb/test_cb_alias_remap.sv
`timescale 1ns/1ps
module test_cb_alias_remap;

  localparam logic [5:0] MASK_EN = 6'b110011;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;

  logic        a_cvld, a_svld, a_err, b_cvld, b_svld, b_err;
  logic [31:0] a_caddr, a_saddr, b_caddr, b_saddr;
  logic [2:0]  a_rgn, b_rgn;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cb_alias_remap i_cb_alias_remap (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .code_vld_o(a_cvld), .code_addr_o(a_caddr), .code_rgn_o(a_rgn),
    .sys_vld_o(a_svld), .sys_addr_o(a_saddr), .err_o(a_err));

  cb_alias_remap #(.WIN_EN(MASK_EN)) i_cb_alias_remap_masked (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .code_vld_o(b_cvld), .code_addr_o(b_caddr), .code_rgn_o(b_rgn),
    .sys_vld_o(b_svld), .sys_addr_o(b_saddr), .err_o(b_err));

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // expected behaviour from the requirements; kind 0 code, 1 system, 2 error
  task automatic expect_of(input logic [31:0] a, input logic [5:0] en,
                           output int kind, output logic [31:0] pa, output logic [2:0] rgn);
    kind = 0; pa = a; rgn = 3'd0;
    if (a >= 32'h2000_0000) kind = 1;
    else if (a < 32'h0080_0000) begin rgn = 3'd0; pa = a; end
    else if (a < 32'h1000_0000) begin rgn = 3'd1; pa = a - 32'h0080_0000 + 32'h8080_0000; end
    else if (a < 32'h1800_0000) begin rgn = 3'd2; pa = a - 32'h1000_0000 + 32'h2000_0000; end
    else if (a < 32'h1F00_0000) begin rgn = 3'd3; pa = a - 32'h1800_0000 + 32'h3000_0000; end
    else if (a < 32'h1F80_0000) begin rgn = 3'd4; pa = a - 32'h1F00_0000 + 32'h3F00_0000; end
    else begin rgn = 3'd5; pa = a; end
    if (kind == 0 && !en[rgn]) kind = 2;
  endtask

  task automatic check_cycle1(string req, logic [31:0] a, logic [5:0] en,
                              logic cvld, logic [31:0] caddr, logic [2:0] rgn, logic err);
    int k; logic [31:0] pa; logic [2:0] r;
    expect_of(a, en, k, pa, r);
    check(req, "code_vld", 32'(cvld), 32'(k == 0));
    check(req, "err", 32'(err), 32'(k == 2));
    if (k == 0) begin
      check(req, "code_addr", caddr, pa);
      check(req, "code_rgn", 32'(rgn), 32'(r));
    end
  endtask

  task automatic check_cycle2(string req, logic [31:0] a, logic [5:0] en,
                              logic svld, logic [31:0] saddr, logic cvld, logic err);
    int k; logic [31:0] pa; logic [2:0] r;
    expect_of(a, en, k, pa, r);
    check(req, "sys_vld", 32'(svld), 32'(k == 1));
    if (k == 1) check(req, "sys_addr", saddr, a);
    check({req, " R11"}, "code_vld idle", 32'(cvld), 32'd0);
    check({req, " R11"}, "err idle", 32'(err), 32'd0);
  endtask

  task automatic fetch(string req, logic [31:0] a);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check_cycle1(req, a, 6'b111111, a_cvld, a_caddr, a_rgn, a_err);
    check_cycle1({req, " masked"}, a, MASK_EN, b_cvld, b_caddr, b_rgn, b_err);
    check(req, "sys_vld early", 32'(a_svld), 32'd0);
    @(negedge clk);
    check_cycle2(req, a, 6'b111111, a_svld, a_saddr, a_cvld, a_err);
    check_cycle2({req, " masked"}, a, MASK_EN, b_svld, b_saddr, b_cvld, b_err);
  endtask

  task automatic test_reset_r1();
    @(negedge clk);
    check("R1", "code_vld", 32'(a_cvld), 0);
    check("R1", "sys_vld", 32'(a_svld), 0);
    check("R1", "err", 32'(a_err), 0);
    check("R1", "masked err", 32'(b_err), 0);
  endtask

  task automatic test_rom_r2();
    fetch("R2", 32'h0000_0000);
    fetch("R2", 32'h0012_3456);
    fetch("R2", 32'h007F_FFFF);
  endtask

  task automatic test_dram_r3();
    fetch("R3", 32'h0080_0000);
    fetch("R3", 32'h0ABC_DEF0);
    fetch("R3", 32'h0FFF_FFFF);
  endtask

  task automatic test_flash_r4();
    fetch("R4 R10", 32'h1000_0000);
    fetch("R4 R10", 32'h17FF_FFFC);
  endtask

  task automatic test_pbus_r5();
    fetch("R5 R10", 32'h1800_0000);
    fetch("R5 R10", 32'h1EFF_FFFF);
  endtask

  task automatic test_sram_r6();
    fetch("R6 R8", 32'h1F00_0000);
    fetch("R6 R8", 32'h1F7F_FFFF);
  endtask

  task automatic test_tcm_r7();
    fetch("R7", 32'h1F80_0000);
    fetch("R7", 32'h1FFF_FFFF);
  endtask

  task automatic test_sys_r9();
    fetch("R9", 32'h2000_0000);
    fetch("R9", 32'h3F00_1234);
    fetch("R9", 32'hFFFF_FFFF);
  endtask

  task automatic test_idle_r11();
    @(negedge clk);
    req_valid = 1'b0; req_addr = 32'h1F00_0040;
    @(negedge clk);
    check("R11", "code_vld", 32'(a_cvld), 0);
    check("R11", "err", 32'(b_err), 0);
    @(negedge clk);
    check("R11", "sys_vld", 32'(a_svld), 0);
  endtask

  task automatic test_b2b_r12();
    @(negedge clk);
    req_valid = 1'b1; req_addr = 32'h3F00_0100;
    @(negedge clk);
    req_addr = 32'h1F00_0200;
    @(negedge clk);
    req_valid = 1'b0;
    check("R12", "sys_vld", 32'(a_svld), 1);
    check("R12", "sys_addr", a_saddr, 32'h3F00_0100);
    check("R12 R8", "code_vld", 32'(a_cvld), 1);
    check("R12 R8", "code_addr", a_caddr, 32'h3F00_0200);
    check("R12", "masked sys_vld", 32'(b_svld), 1);
    check("R12", "masked code_vld", 32'(b_cvld), 1);
    @(negedge clk);
    check("R12", "sys_vld drop", 32'(a_svld), 0);
    check("R12", "code_vld drop", 32'(a_cvld), 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    test_reset_r1();
    rst_n = 1'b1;
    test_reset_r1();
    test_rom_r2();
    test_dram_r3();
    test_flash_r4();
    test_pbus_r5();
    test_sram_r6();
    test_tcm_r7();
    test_sys_r9();
    test_idle_r11();
    test_b2b_r12();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule